// File: doc/BRIEF.md
# Serial Control and Diagnosis Register

This block is the serial slave that sits between a host controller and a set of power switches and transceiver controls. The host runs 16-clock frames: while chip select is low it shifts a control word in, least significant bit first, and at the same time receives a diagnosis word. The diagnosis word is a snapshot of the status flags taken when chip select falls. The control word only takes effect when chip select rises.

The block decodes the stored control word into enables for three high-side and two low-side switches. High-side switch 1 can also follow an external PWM input. High-side switch 3 can run a self-timed wake-up pulse of 2 ticks in every 128 ticks of a slow cycle tick. The watchdog, supervisor and transceiver mode bits go straight out to neighbouring blocks. All serial pins pass through two-stage synchronisers into the system clock domain and are edge-detected there. Undervoltage lockout, the undercurrent watchdog-off state and reset each override the switch enables.

Top module: `spi_ctrl_diag`

## Requirements
- R1: `sdo_oe_o` is 0 whenever the synchronised select is high. It rises 2 clocks after `sel_n_i` falls and drops 2 clocks after it rises. `sdo_o` reads 0 while `sdo_oe_o` is 0.
- R2: While select is low, each falling serial-clock edge shifts `sdi_i` into the top of a 16-bit shift register that moves toward bit 0. The first bit sent therefore lands in bit 0. Serial-clock edges seen while select is high change nothing.
- R3: On the rising edge of select, bits 11..0 of the shift register become the active control word. The control word is constant at all other times.
- R4: On the falling edge of select, the diagnosis word is captured. Its bit layout is: bit 0 prewarning, 1 high-side-1 overload, 2 watchdog reset, 3 `uvlo_i`, 4 constant 0, 5/6 the current low-side enables 1/2, 7 Vcc low, 13..8 `can_fail_i[5:0]`, 14 switch thermal shutdown, 15 transceiver thermal shutdown. The word is shifted out from bit 0 upward, one bit per rising serial-clock edge, and the first bit appears after the first rising edge. Status changes after capture do not alter the word being sent.
- R5: High-side 1 is on when control bit 1 is set, or when control bit 11 is set and PWM is high. When bit 1 is set, PWM has no effect.
- R6: High-side 2 follows control bit 2. Low-side 1 and low-side 2 follow control bits 5 and 6.
- R7: With control bit 3 alone set, high-side 3 is steadily on. With bits 3 and 4 both set, it is on for the first 2 of every 128 ticks of `tick_i`. With bit 4 alone set, it stays off.
- R8: While `uvlo_i` is high, every switch enable is 0 from the next clock onward.
- R9: While `undercur_i` is high and control bit 8 is set, both low-side enables are 0.
- R10: Reset clears the control word, every switch enable, every pass-through output and `sdo_oe_o`.
- R11: Control bits 0, 7, 8, 9 and 10 appear on `wd_trig_o`, `sup_en_o`, `wd_uc_off_o`, `can_nstb_o` and `can_txen_o`.
- R12: A frame with fewer or more than 16 falling serial-clock edges still applies the shift register contents at select rise. The shift register is cleared to zero at select fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_n_i | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| pwm_i | input | 1 | PWM control for high-side 1 |
| tick_i | input | 1 | One-clock pulse per slow timing cycle |
| uvlo_i | input | 1 | Supply undervoltage lockout |
| undercur_i | input | 1 | Load current below watchdog threshold |
| therm_warn_i | input | 1 | Thermal prewarning flag |
| hs1_ovl_i | input | 1 | High-side 1 overload flag |
| wd_rst_i | input | 1 | Watchdog reset occurred flag |
| vcc_low_i | input | 1 | Supply below 3 V flag |
| can_fail_i | input | 6 | Bus failure group flags |
| therm_sw_i | input | 1 | Switch thermal shutdown flag |
| therm_can_i | input | 1 | Transceiver thermal shutdown flag |
| hs_en_o | output | 3 | High-side enables 1..3 (bit 0 = switch 1) |
| ls_en_o | output | 2 | Low-side enables 1..2 |
| wd_trig_o | output | 1 | Watchdog trigger bit |
| sup_en_o | output | 1 | Supervisor enable bit |
| wd_uc_off_o | output | 1 | Watchdog undercurrent disable bit |
| can_nstb_o | output | 1 | Transceiver not-standby bit |
| can_txen_o | output | 1 | Transceiver transmit enable bit |

## Verification
Two pairs of functions can land on the same clock. First, the control word is applied at select rise while undervoltage lockout is also asserted. Second, the status snapshot is taken at select fall while the status inputs change during the frame. The bench raises `uvlo_i` on the very clock that chip select is released, and then expects all enables to stay at 0 until lockout clears, after which the new word shows. It also alters the status flags mid-frame and expects the word that was read back to match the flags held at select fall. A behavioural model compares every output on every clock, so the same-cycle ordering is judged at the exact edge where it occurs.

// File: rtl/spicd_pkg.sv
package spicd_pkg;

    localparam int WORD_W      = 16;
    localparam int CTRL_W      = 12;
    localparam int AUTO_PERIOD = 128;
    localparam int AUTO_ON     = 2;
    localparam int AUTO_CNT_W  = $clog2(AUTO_PERIOD);

    // control word bit positions (decoded by neighbours, so fixed)
    localparam int C_WDTRIG = 0;
    localparam int C_HS1    = 1;
    localparam int C_HS2    = 2;
    localparam int C_HS3    = 3;
    localparam int C_AUTO   = 4;
    localparam int C_LS1    = 5;
    localparam int C_LS2    = 6;
    localparam int C_SUPEN  = 7;
    localparam int C_WDUC   = 8;
    localparam int C_NSTB   = 9;
    localparam int C_TXEN   = 10;
    localparam int C_PWMEN  = 11;

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] tx;
        logic [CTRL_W-1:0] ctrl;
        logic              sdo;
        logic              cs_prv;
        logic              sck_prv;
    } ser_st_t;

    typedef struct packed {
        logic [AUTO_CNT_W-1:0] cnt;
        logic [2:0]            hs;
        logic [1:0]            ls;
    } sw_st_t;

endpackage

// File: rtl/spicd_sync.sv
module spicd_sync #(
    parameter int         W   = 2,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sy_st_t;

    sy_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{s1: RST, s2: RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.s2;

endmodule

// File: rtl/spicd_serial.sv
module spicd_serial
    import spicd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_lvl_i,
    input  logic              sck_lvl_i,
    input  logic              sdi_lvl_i,
    input  logic [WORD_W-1:0] diag_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    ser_st_t st_d, st_q;
    logic    active;
    logic    sel_fall;
    logic    sel_rise;
    logic    sck_fall;
    logic    sck_rise;

    assign active   = !cs_lvl_i;
    assign sel_fall = st_q.cs_prv && !cs_lvl_i;
    assign sel_rise = !st_q.cs_prv && cs_lvl_i;
    assign sck_fall = st_q.sck_prv && !sck_lvl_i;
    assign sck_rise = !st_q.sck_prv && sck_lvl_i;

    always_comb begin
        st_d         = st_q;
        st_d.cs_prv  = cs_lvl_i;
        st_d.sck_prv = sck_lvl_i;
        if (sel_fall) begin
            st_d.sr  = '0;
            st_d.tx  = diag_i;
            st_d.sdo = 1'b0;
        end else if (active && sck_fall) begin
            st_d.sr = {sdi_lvl_i, st_q.sr[WORD_W-1:1]};
        end else if (active && sck_rise) begin
            st_d.sdo = st_q.tx[0];
            st_d.tx  = {1'b0, st_q.tx[WORD_W-1:1]};
        end
        if (sel_rise) begin
            st_d.ctrl = st_q.sr[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{sr: '0, tx: '0, ctrl: '0, sdo: 1'b0,
                      cs_prv: 1'b1, sck_prv: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o   = st_q.ctrl;
    assign sdo_oe_o = active;
    assign sdo_o    = active & st_q.sdo;

    // R3
    ctrl_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.ctrl) |-> $past(sel_rise));

    // R2
    sr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(cs_lvl_i) |-> $stable(st_q.sr));

endmodule

// File: rtl/spicd_switch.sv
module spicd_switch
    import spicd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] hs_req_i,
    input  logic       auto_i,
    input  logic [1:0] ls_req_i,
    input  logic       pwm_en_i,
    input  logic       wduc_i,
    input  logic       pwm_lvl_i,
    input  logic       tick_i,
    input  logic       uvlo_i,
    input  logic       uc_i,
    output logic [2:0] hs_o,
    output logic [1:0] ls_o
);

    localparam logic [AUTO_CNT_W-1:0] CNT_LAST = AUTO_CNT_W'(AUTO_PERIOD - 1);
    localparam logic [AUTO_CNT_W-1:0] CNT_ON   = AUTO_CNT_W'(AUTO_ON);

    sw_st_t st_d, st_q;
    logic   auto_run;
    logic   pulse;
    logic   ls_block;

    assign auto_run = hs_req_i[2] && auto_i;
    assign pulse    = st_q.cnt < CNT_ON;
    assign ls_block = uc_i && wduc_i;

    always_comb begin
        st_d = st_q;
        if (auto_run) begin
            if (tick_i) begin
                st_d.cnt = (st_q.cnt == CNT_LAST) ? '0 : st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
        st_d.hs[0] = hs_req_i[0] || (pwm_en_i && pwm_lvl_i);
        st_d.hs[1] = hs_req_i[1];
        st_d.hs[2] = auto_run ? pulse : hs_req_i[2];
        for (int i = 0; i < 2; i++) begin
            st_d.ls[i] = ls_req_i[i] && !ls_block;
        end
        if (uvlo_i) begin
            st_d.hs = '0;
            st_d.ls = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_o = st_q.hs;
    assign ls_o = st_q.ls;

    // R8
    uvlo_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uvlo_i |=> (hs_o == 3'b000 && ls_o == 2'b00));

    // R9
    uc_ls_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (uc_i && wduc_i) |=> (ls_o == 2'b00));

    // R5
    hs1_spi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!uvlo_i && hs_req_i[0]) |=> hs_o[0]);

endmodule

// File: rtl/spi_ctrl_diag.sv
module spi_ctrl_diag
    import spicd_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sel_n_i,
    input  logic       sck_i,
    input  logic       sdi_i,
    output logic       sdo_o,
    output logic       sdo_oe_o,
    input  logic       pwm_i,
    input  logic       tick_i,
    input  logic       uvlo_i,
    input  logic       undercur_i,
    input  logic       therm_warn_i,
    input  logic       hs1_ovl_i,
    input  logic       wd_rst_i,
    input  logic       vcc_low_i,
    input  logic [5:0] can_fail_i,
    input  logic       therm_sw_i,
    input  logic       therm_can_i,
    output logic [2:0] hs_en_o,
    output logic [1:0] ls_en_o,
    output logic       wd_trig_o,
    output logic       sup_en_o,
    output logic       wd_uc_off_o,
    output logic       can_nstb_o,
    output logic       can_txen_o
);

    logic [3:0]        pins_sync;
    logic [CTRL_W-1:0] ctrl;
    logic [WORD_W-1:0] diag;
    logic [1:0]        ls_now;

    // pin order: {pwm, sdi, sck, sel_n}; select idles high
    spicd_sync #(.W(4), .RST(4'b0001)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({pwm_i, sdi_i, sck_i, sel_n_i}),
        .sync_o  (pins_sync)
    );

    assign diag = {therm_can_i, therm_sw_i, can_fail_i, vcc_low_i,
                   ls_now, 1'b0, uvlo_i, wd_rst_i, hs1_ovl_i, therm_warn_i};

    spicd_serial u_serial (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cs_lvl_i  (pins_sync[0]),
        .sck_lvl_i (pins_sync[1]),
        .sdi_lvl_i (pins_sync[2]),
        .diag_i    (diag),
        .ctrl_o    (ctrl),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o)
    );

    spicd_switch u_switch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hs_req_i  ({ctrl[C_HS3], ctrl[C_HS2], ctrl[C_HS1]}),
        .auto_i    (ctrl[C_AUTO]),
        .ls_req_i  ({ctrl[C_LS2], ctrl[C_LS1]}),
        .pwm_en_i  (ctrl[C_PWMEN]),
        .wduc_i    (ctrl[C_WDUC]),
        .pwm_lvl_i (pins_sync[3]),
        .tick_i    (tick_i),
        .uvlo_i    (uvlo_i),
        .uc_i      (undercur_i),
        .hs_o      (hs_en_o),
        .ls_o      (ls_now)
    );

    assign ls_en_o     = ls_now;
    assign wd_trig_o   = ctrl[C_WDTRIG];
    assign sup_en_o    = ctrl[C_SUPEN];
    assign wd_uc_off_o = ctrl[C_WDUC];
    assign can_nstb_o  = ctrl[C_NSTB];
    assign can_txen_o  = ctrl[C_TXEN];

    // R1
    oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_n_i && $past(sel_n_i) && $past(sel_n_i, 2)) |-> !sdo_oe_o);

endmodule

// File: tb/spi_ctrl_diag_test.sv
module spi_ctrl_diag_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0, pwm = 1'b0, tick = 1'b0;
    logic uvlo = 1'b0, uc = 1'b0;
    logic [15:0] stat = 16'h0000;
    logic sdo, sdo_oe, wd_trig, sup_en, wd_uc_off, can_nstb, can_txen;
    logic [2:0] hs_en;
    logic [1:0] ls_en;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    spi_ctrl_diag uut (
        .clk_i(clk), .rst_ni(rst_n), .sel_n_i(sel_n), .sck_i(sck), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .pwm_i(pwm), .tick_i(tick),
        .uvlo_i(uvlo), .undercur_i(uc),
        .therm_warn_i(stat[0]), .hs1_ovl_i(stat[1]), .wd_rst_i(stat[2]),
        .vcc_low_i(stat[7]), .can_fail_i(stat[13:8]),
        .therm_sw_i(stat[14]), .therm_can_i(stat[15]),
        .hs_en_o(hs_en), .ls_en_o(ls_en), .wd_trig_o(wd_trig), .sup_en_o(sup_en),
        .wd_uc_off_o(wd_uc_off), .can_nstb_o(can_nstb), .can_txen_o(can_txen)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic        h_cs[$], h_sck[$], h_sdi[$], h_pwm[$];
    logic [15:0] m_sr, m_tx;
    logic [11:0] m_ctrl;
    logic        m_sdo;
    int          m_ticks;
    logic [2:0]  m_hs;
    logic [1:0]  m_ls;
    logic        cs_prev, sck_prev;

    function automatic logic [15:0] diag_of(logic [15:0] s, logic [1:0] l, logic uv);
        return {s[15:7], l, 1'b0, uv, s[2:0]};
    endfunction

    task automatic model_reset();
        h_cs = '{1'b1, 1'b1}; h_sck = '{1'b0, 1'b0};
        h_sdi = '{1'b0, 1'b0}; h_pwm = '{1'b0, 1'b0};
        m_sr = 0; m_tx = 0; m_ctrl = 0; m_sdo = 0; m_ticks = 0;
        m_hs = 0; m_ls = 0; cs_prev = 1'b1; sck_prev = 1'b0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            logic cs_now, sck_now, sdi_now, pwm_now, autorun;
            logic [2:0] n_hs;
            logic [1:0] n_ls;
            cs_now = h_cs[1]; sck_now = h_sck[1]; sdi_now = h_sdi[1]; pwm_now = h_pwm[1];
            autorun = m_ctrl[3] && m_ctrl[4];
            n_hs[0] = m_ctrl[1] || (m_ctrl[11] && pwm_now);
            n_hs[1] = m_ctrl[2];
            n_hs[2] = autorun ? ((m_ticks % 128) < 2) : m_ctrl[3];
            n_ls    = (uc && m_ctrl[8]) ? 2'b00 : {m_ctrl[6], m_ctrl[5]};
            if (uvlo) begin n_hs = 0; n_ls = 0; end
            if (autorun) begin if (tick) m_ticks++; end else m_ticks = 0;
            if (cs_prev && !cs_now) begin
                m_sr = 0; m_tx = diag_of(stat, m_ls, uvlo); m_sdo = 0;
            end else if (!cs_now && sck_prev && !sck_now) begin
                m_sr = {sdi_now, m_sr[15:1]};
            end else if (!cs_now && !sck_prev && sck_now) begin
                m_sdo = m_tx[0]; m_tx = m_tx >> 1;
            end
            if (!cs_prev && cs_now) m_ctrl = m_sr[11:0];
            m_hs = n_hs; m_ls = n_ls;
            cs_prev = cs_now; sck_prev = sck_now;
            h_cs.push_front(sel_n);  void'(h_cs.pop_back());
            h_sck.push_front(sck);   void'(h_sck.pop_back());
            h_sdi.push_front(sdi);   void'(h_sdi.pop_back());
            h_pwm.push_front(pwm);   void'(h_pwm.pop_back());
        end
    end

    always @(posedge clk) begin
        #2;
        cycles++;
        if (cmp_on) begin
            logic exp_oe;
            exp_oe = rst_n ? !h_cs[1] : 1'b0;
            chk("R1 sdo_oe", sdo_oe, exp_oe);
            chk("R4 sdo", sdo, exp_oe & m_sdo);
            chk("R5 hs1", hs_en[0], m_hs[0]);
            chk("R6 hs2", hs_en[1], m_hs[1]);
            chk("R7 hs3", hs_en[2], m_hs[2]);
            chk("R6 ls", ls_en, m_ls);
            chk("R11 passthrough", {can_txen, can_nstb, wd_uc_off, sup_en, wd_trig},
                {m_ctrl[10], m_ctrl[9], m_ctrl[8], m_ctrl[7], m_ctrl[0]});
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    function automatic logic [11:0] word_after(logic [15:0] w, int n);
        logic [15:0] s = 0;
        for (int i = 0; i < n; i++) s = {w[i % 16], s[15:1]};
        return s[11:0];
    endfunction

    task automatic frame(input logic [15:0] w, input int n, output logic [15:0] rd);
        rd = 0;
        @(negedge clk) sel_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi = w[i % 16];
            sck = 1'b1;
            repeat (6) @(negedge clk);
            if (i < 16) rd[i] = sdo;
            sck = 1'b0;
            repeat (6) @(negedge clk);
        end
        sel_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic chk_outs(input string tag, input logic [11:0] c);
        chk({tag, " hs"}, hs_en, {c[3] & ~c[4], c[2], c[1]});
        chk({tag, " ls"}, ls_en, {c[6], c[5]});
        chk({tag, " pass"}, {can_txen, can_nstb, wd_uc_off, sup_en, wd_trig},
            {c[10], c[9], c[8], c[7], c[0]});
    endtask

    initial begin
        logic [15:0] rd;
        int on_cnt;
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        // R10 reset state
        chk("R10 reset hs", hs_en, 3'b000);
        chk("R10 reset ls", ls_en, 2'b00);
        chk("R10 reset oe", sdo_oe, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R5 basic word, R4 diagnosis readback
        stat = 16'hA587;
        frame(16'h0002, 16, rd);
        chk("R4 diag word", rd, diag_of(16'hA587, 2'b00, 1'b0));
        chk_outs("R3 R5 word 0002", 12'h002);

        // R5 PWM gating and masking
        frame(16'h0800, 16, rd);
        pwm = 1'b1; repeat (5) @(negedge clk);
        chk("R5 pwm high", hs_en[0], 1'b1);
        pwm = 1'b0; repeat (5) @(negedge clk);
        chk("R5 pwm low", hs_en[0], 1'b0);
        frame(16'h0802, 16, rd);
        chk("R5 spi masks pwm", hs_en[0], 1'b1);

        // R6 and R4 low-side status reflected in diagnosis; status change mid-frame
        frame(16'h0064, 16, rd);
        chk_outs("R6 word 0064", 12'h064);
        stat = 16'h5A78;
        fork
            frame(16'h0064, 16, rd);
            begin repeat (40) @(negedge clk); stat = 16'hFFFF; end
        join
        chk("R4 snapshot with ls", rd, diag_of(16'h5A78, 2'b11, 1'b0));
        stat = 16'h0000;

        // R11 pass-through
        frame(16'hF781, 16, rd);
        chk_outs("R11 word 0781", 12'h781);

        // R9 undercurrent
        frame(16'h0160, 16, rd);
        chk("R9 ls before", ls_en, 2'b11);
        uc = 1'b1; repeat (3) @(negedge clk);
        chk("R9 ls forced off", ls_en, 2'b00);
        uc = 1'b0; repeat (3) @(negedge clk);
        chk("R9 ls back", ls_en, 2'b11);

        // R7 auto timing
        frame(16'h0018, 16, rd);
        on_cnt = 0;
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            if (hs_en[2]) on_cnt++;
        end
        chk("R7 auto on-cycles per period", on_cnt, 8);
        frame(16'h0008, 16, rd);
        chk("R7 steady on", hs_en[2], 1'b1);
        frame(16'h0010, 16, rd);
        chk("R7 auto bit alone", hs_en[2], 1'b0);

        // R8 lockout on the same clock the word is applied
        @(negedge clk) sel_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            sdi = (16'h0066 >> i) & 1; sck = 1'b1;
            repeat (6) @(negedge clk);
            sck = 1'b0;
            repeat (6) @(negedge clk);
        end
        sel_n = 1'b1;
        repeat (2) @(negedge clk);
        uvlo = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8 uvlo hs off", hs_en, 3'b000);
        chk("R8 uvlo ls off", ls_en, 2'b00);
        uvlo = 1'b0; repeat (3) @(negedge clk);
        chk_outs("R8 released", 12'h066);

        // R2 clock edges with select high are ignored
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1; sck = 1'b1; repeat (4) @(negedge clk);
            sck = 1'b0; repeat (4) @(negedge clk);
        end
        chk_outs("R2 idle clocks", 12'h066);

        // R12 short and long frames
        frame(16'h00FF, 8, rd);
        chk_outs("R12 short frame", word_after(16'h00FF, 8));
        frame(16'h0A5C, 20, rd);
        chk_outs("R12 long frame", word_after(16'h0A5C, 20));
        frame(16'h0000, 0, rd);
        chk_outs("R12 empty frame", 12'h000);

        // R10 reset mid-run
        frame(16'h07E6, 16, rd);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk_outs("R10 mid reset", 12'h000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        frame(16'h0004, 16, rd);
        chk_outs("R10 after reset", 12'h004);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule